// File: doc/BRIEF.md
# Single-Digit Keypad Calculator Sequencer

This block sits behind a keypad scanner and debouncer. It takes one key code per key-valid strobe and steps through a fixed entry order: a first one-digit operand, an operator, a second one-digit operand, and finally the equals key. When equals arrives it computes the sum, difference or product of the two operands.

The block drives an 8-bit unsigned binary display value. After the first operand is entered, that value shows the operand. The operator step leaves the value as it is. After the second operand, the value shows that operand, and after equals it shows the result. A key that does not fit the current step is dropped. A subtraction that would go below zero shows 0 and raises a negative flag. A synchronous clear restarts entry at any point.

Top module: `keypad_calc`

## Requirements
- R1: In the first-operand step, a strobed key code 0 to 9 stores that digit, places it on `disp_value`, clears `neg_flag` and moves to the operator step.
- R2: In the operator step, code 10 selects addition, code 11 selects subtraction and code 12 selects multiplication. The machine then moves to the second-operand step, and `disp_value` keeps showing the first operand.
- R3: In the second-operand step, a strobed code 0 to 9 stores that digit, places it on `disp_value` and moves to the equals step.
- R4: In the equals step, code 13 places the result of the selected operation on `disp_value`, one clock after the strobe. The display value never exceeds 81, which is 9 times 9; for example 5 times 6 shows 30.
- R5: If the first operand is smaller than the second under subtraction, the result shows as 0 and `neg_flag` goes to 1. The flag stays set until the display next changes or a clear or reset occurs. `neg_flag` is 1 only while `disp_value` is 0.
- R6: A strobed key of the wrong class for the current step leaves the step, `disp_value` and `neg_flag` unchanged. Examples are a digit in the operator step, an operator or digit in the equals step, and equals or an operator in either operand step.
- R7: Codes 14 and above are ignored in every step.
- R8: State, display and flag change only on a cycle in which `key_valid` is 1. A key code held with `key_valid` at 0 has no effect.
- R9: `clr` (and `rst`) at a clock edge returns the machine to the first-operand step, with `disp_value` at 0 and `neg_flag` at 0. This overrides a key strobed in the same cycle.
- R10: After the equals step the machine waits for a new first operand. The step advances by at most one position per clock, in the order first operand, operator, second operand, equals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the entry sequence |
| key_valid | input | 1 | One-cycle strobe marking a new debounced key |
| key_code | input | 5 | Key code: 0-9 digits, 10 add, 11 subtract, 12 multiply, 13 equals |
| disp_value | output | 8 | Unsigned binary value for the display |
| neg_flag | output | 1 | Set with a clamped negative subtraction result |

## Verification
The checker enforces several properties on every cycle:
- Nothing moves without a strobe.
- Clear forces the zero state.
- The display stays within 81.
- The negative flag appears only with a zero display and only on leaving the equals step.
- The step walks forward by at most one position.

Which operand or result value is shown, the operator mapping and clamping, and the rejection of each wrong-class or out-of-range code can only be shown by the bench. It does this by comparing every clock against its behavioural model, over full sweeps of operands and operators and over targeted misuse sequences.

// File: rtl/calc_pkg.sv
package calc_pkg;
    localparam int KEY_W      = 5;
    localparam int DIG_W      = 4;
    localparam int DISP_W     = 8;
    localparam int MAX_DIGIT  = 9;
    localparam int MAX_RESULT = MAX_DIGIT * MAX_DIGIT;

    localparam int CODE_ADD = 10;
    localparam int CODE_SUB = 11;
    localparam int CODE_MUL = 12;
    localparam int CODE_EQ  = 13;

    typedef enum logic [1:0] {
        ST_OPA = 2'd0,
        ST_OPR = 2'd1,
        ST_OPB = 2'd2,
        ST_EQU = 2'd3
    } step_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2
    } op_t;

    typedef struct packed {
        logic             is_digit;
        logic             is_op;
        logic             is_eq;
        logic [DIG_W-1:0] digit;
        op_t              op;
    } key_class_t;
endpackage

// File: rtl/calc_key_class.sv
module calc_key_class
    import calc_pkg::*;
#(
    parameter int CODE_W = KEY_W
) (
    input  logic [CODE_W-1:0] code,
    output key_class_t        cls
);
    always_comb begin
        cls          = '0;
        cls.is_digit = (code <= CODE_W'(MAX_DIGIT));
        cls.digit    = code[DIG_W-1:0];
        cls.is_eq    = (code == CODE_W'(CODE_EQ));
        cls.op       = OP_ADD;
        if (code == CODE_W'(CODE_ADD)) begin
            cls.is_op = 1'b1;
            cls.op    = OP_ADD;
        end else if (code == CODE_W'(CODE_SUB)) begin
            cls.is_op = 1'b1;
            cls.op    = OP_SUB;
        end else if (code == CODE_W'(CODE_MUL)) begin
            cls.is_op = 1'b1;
            cls.op    = OP_MUL;
        end
    end
endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
#(
    parameter int OUT_W = DISP_W
) (
    input  logic [DIG_W-1:0] opa,
    input  logic [DIG_W-1:0] opb,
    input  op_t              op,
    output logic [OUT_W-1:0] result,
    output logic             negative
);
    localparam int PAD = OUT_W - DIG_W;

    logic [OUT_W-1:0] a_ext;
    logic [OUT_W-1:0] b_ext;

    assign a_ext = {{PAD{1'b0}}, opa};
    assign b_ext = {{PAD{1'b0}}, opb};

    always_comb begin
        result   = '0;
        negative = 1'b0;
        unique case (op)
            OP_ADD: result = a_ext + b_ext;
            OP_SUB: begin
                if (opa < opb) begin
                    negative = 1'b1;
                end else begin
                    result = a_ext - b_ext;
                end
            end
            OP_MUL: result = a_ext * b_ext;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/keypad_calc.sv
module keypad_calc
    import calc_pkg::*;
#(
    parameter int CODE_W = KEY_W,
    parameter int OUT_W  = DISP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    output logic [OUT_W-1:0]  disp_value,
    output logic              neg_flag
);
    step_t            step_q;
    op_t              op_q;
    logic [DIG_W-1:0] opa_q;
    logic [DIG_W-1:0] opb_q;
    logic [OUT_W-1:0] disp_q;
    logic             neg_q;

    key_class_t       cls;
    logic [OUT_W-1:0] alu_res;
    logic             alu_neg;

    calc_key_class #(.CODE_W(CODE_W)) u_class (
        .code (key_code),
        .cls  (cls)
    );

    calc_alu #(.OUT_W(OUT_W)) u_alu (
        .opa      (opa_q),
        .opb      (opb_q),
        .op       (op_q),
        .result   (alu_res),
        .negative (alu_neg)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            step_q <= ST_OPA;
            op_q   <= OP_ADD;
            opa_q  <= '0;
            opb_q  <= '0;
            disp_q <= '0;
            neg_q  <= 1'b0;
        end else if (key_valid) begin
            unique case (step_q)
                ST_OPA: if (cls.is_digit) begin
                    opa_q  <= cls.digit;
                    disp_q <= OUT_W'(cls.digit);
                    neg_q  <= 1'b0;
                    step_q <= ST_OPR;
                end
                ST_OPR: if (cls.is_op) begin
                    op_q   <= cls.op;
                    step_q <= ST_OPB;
                end
                ST_OPB: if (cls.is_digit) begin
                    opb_q  <= cls.digit;
                    disp_q <= OUT_W'(cls.digit);
                    step_q <= ST_EQU;
                end
                ST_EQU: if (cls.is_eq) begin
                    disp_q <= alu_res;
                    neg_q  <= alu_neg;
                    step_q <= ST_OPA;
                end
                default: step_q <= ST_OPA;
            endcase
        end
    end

    assign disp_value = disp_q;
    assign neg_flag   = neg_q;
endmodule

// File: rtl/calc_checker.sv
module calc_checker
    import calc_pkg::*;
#(
    parameter int OUT_W = DISP_W
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             key_valid,
    input logic [OUT_W-1:0] disp_value,
    input logic             neg_flag,
    input logic [1:0]       step
);
    a_r9_clear_state: assert property (@(posedge clk) disable iff (rst)
        clr |=> (disp_value == '0) && !neg_flag && (step == 2'd0));

    a_r8_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        (!key_valid && !clr) |=> $stable(disp_value) && $stable(neg_flag) && $stable(step));

    a_r4_range: assert property (@(posedge clk) disable iff (rst)
        disp_value <= OUT_W'(MAX_RESULT));

    a_r5_neg_zero: assert property (@(posedge clk) disable iff (rst)
        neg_flag |-> (disp_value == '0));

    a_r5_neg_from_equals: assert property (@(posedge clk) disable iff (rst)
        $rose(neg_flag) |-> ($past(step) == 2'd3) && (step == 2'd0));

    a_r10_step_order: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (step == $past(step)) || (step == 2'($past(step) + 2'd1)));
endmodule

bind keypad_calc calc_checker #(.OUT_W(OUT_W)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .key_valid  (key_valid),
    .disp_value (disp_value),
    .neg_flag   (neg_flag),
    .step       (step_q)
);

// File: tb/tb_keypad_calc.sv
module tb_keypad_calc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       key_valid = 1'b0;
    logic [4:0] key_code = '0;
    logic [7:0] disp_value;
    logic       neg_flag;

    int n_total = 0;
    int n_fail  = 0;

    // behavioural reference
    int m_step = 0;
    int m_a = 0, m_b = 0, m_op = 0;
    int m_disp = 0;
    int m_neg = 0;

    always #4 clk = ~clk;

    keypad_calc dut (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .key_valid  (key_valid),
        .key_code   (key_code),
        .disp_value (disp_value),
        .neg_flag   (neg_flag)
    );

    task automatic check_val(string tag, int act, int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(int v, int code, int c);
        if (c != 0) begin
            m_step = 0; m_disp = 0; m_neg = 0;
        end else if (v != 0) begin
            case (m_step)
                0: if (code <= 9) begin m_a = code; m_disp = code; m_neg = 0; m_step = 1; end
                1: if (code >= 10 && code <= 12) begin m_op = code; m_step = 2; end
                2: if (code <= 9) begin m_b = code; m_disp = code; m_step = 3; end
                default: if (code == 13) begin
                    if (m_op == 10) begin m_disp = m_a + m_b; m_neg = 0; end
                    else if (m_op == 12) begin m_disp = m_a * m_b; m_neg = 0; end
                    else if (m_a < m_b) begin m_disp = 0; m_neg = 1; end
                    else begin m_disp = m_a - m_b; m_neg = 0; end
                    m_step = 0;
                end
            endcase
        end
    endtask

    // called at a negedge: drive, clock, compare at the next negedge
    task automatic cyc(int v, int code, int c, string tag);
        key_valid = v[0];
        key_code  = 5'(code);
        clr       = c[0];
        @(posedge clk);
        model_step(v, code, c);
        @(negedge clk);
        check_val({tag, " disp"}, int'(disp_value), m_disp);
        check_val({tag, " neg"}, int'(neg_flag), m_neg);
        key_valid = 1'b0;
        clr       = 1'b0;
    endtask

    // strobe a key, then hold the code one cycle without strobe
    task automatic press(int code, string tag);
        cyc(1, code, 0, tag);
        cyc(0, code, 0, {tag, " R8 held"});
    endtask

    task automatic run_seq(int a, int op, int b, string tag);
        press(a, {tag, " R1"});
        press(op, {tag, " R2"});
        press(b, {tag, " R3"});
        press(13, {tag, " R4"});
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_val("R9 reset disp", int'(disp_value), 0);
        check_val("R9 reset neg", int'(neg_flag), 0);

        // 1 + 3 = 4
        run_seq(1, 10, 3, "add13");
        check_val("R4 1+3", int'(disp_value), 4);
        // 5 * 6 = 30
        run_seq(5, 12, 6, "mul56");
        check_val("R4 5x6", int'(disp_value), 30);
        run_seq(9, 12, 9, "mul99");
        check_val("R4 9x9 max", int'(disp_value), 81);
        run_seq(8, 11, 3, "sub83");
        check_val("R5 8-3", int'(disp_value), 5);
        run_seq(2, 11, 7, "sub27");
        check_val("R5 2-7 clamp", int'(disp_value), 0);
        check_val("R5 2-7 flag", int'(neg_flag), 1);
        cyc(0, 0, 0, "R5 flag holds");
        press(13, "R10 equals after result ignored");
        check_val("R5 flag still set", int'(neg_flag), 1);
        press(4, "R10 new first operand");
        check_val("R5 flag cleared by new digit", int'(neg_flag), 0);
        check_val("R1 digit shown", int'(disp_value), 4);

        // R6 wrong class keys in each step
        press(7, "R6 digit in operator step");
        press(13, "R6 equals in operator step");
        check_val("R6 operand kept", int'(disp_value), 4);
        press(11, "R2 subtract");
        press(12, "R6 operator in operand step");
        press(13, "R6 equals before second operand");
        press(2, "R3 second");
        press(5, "R6 digit in equals step");
        press(10, "R6 operator in equals step");
        check_val("R6 second kept", int'(disp_value), 2);
        press(13, "R4 4-2");
        check_val("R4 4-2", int'(disp_value), 2);

        // R7 out-of-range codes in every step
        for (int s = 0; s < 4; s++) begin
            press(14, "R7 code14");
            press(15, "R7 code15");
            press(31, "R7 code31");
            press((s == 1) ? 10 : ((s == 3) ? 13 : 3), "R7 advance");
        end

        // R9 clear mid sequence and clear with strobe
        press(6, "R1 before clear");
        press(10, "R2 before clear");
        cyc(0, 0, 1, "R9 clear");
        check_val("R9 cleared disp", int'(disp_value), 0);
        press(12, "R6 operator after clear");
        cyc(1, 7, 1, "R9 clear beats strobe");
        check_val("R9 clear beats strobe value", int'(disp_value), 0);
        press(3, "R1 after clear");
        press(12, "R2 after clear");
        cyc(0, 0, 1, "R9 clear in second step");

        // full sweep of operands and operators
        for (int o = 10; o <= 12; o++)
            for (int a = 0; a <= 9; a++)
                for (int b = 0; b <= 9; b++)
                    run_seq(a, o, b, "sweep");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule